// File: doc/BRIEF.md
# Pulse-Swallow Divide Controller

This block sits between an external dual-modulus prescaler (dividing by P or P+1) and a phase detector. It turns the prescaler output into a reference-rate pulse train whose period is NT cycles of the VCO, with NT = N·P + A. It is clocked by the prescaler output `fin`. It holds two down-counters: a main counter that counts N prescaler periods and a swallow counter that counts A of those periods. While the swallow counter is non-zero, `modCtl` asks the prescaler for P+1. After that, `modCtl` asks for P until the main counter ends the cycle. Both counters then reload together, and `divOut` pulses once.

P is restricted to a power of two (8, 16, 32 or 64, chosen by `pSel`). Because of that restriction, software writes NT as one plain binary word. The lowest a bits (2^a = P) become A, and the bits above them become N. Every swallow-counter bit above a-1 is forced to zero. The configuration must keep N ≥ A and N ≥ 1. The word is only sampled when the counters reload, so a write takes effect cleanly at the next cycle boundary.

Top module: `swallow_div`

## Requirements
- R1: While `rst` is high at a `fin` rising edge, `divOut` is driven low and both counters load from the program word, so `modCtl` is high exactly when the decoded A is non-zero.
- R2: `pSel` values 0, 1, 2 and 3 select P = 8, 16, 32 and 64 (a = 3, 4, 5, 6). A is `progWord[a-1:0]`, N is `progWord[a+9:a]`, and all swallow-counter bits at position a and above stay zero.
- R3: With a correct P/P+1 prescaler, successive `divOut` rising edges are exactly NT = `progWord[n+a-1:0]` VCO cycles apart (n = 10).
- R4: Each divide cycle spans exactly N prescaler periods. `modCtl` is high for the first A of them and low for the remaining N−A.
- R5: When A is zero, `modCtl` stays low for the whole cycle.
- R6: Program word bits at positions n+a and above have no effect on the divide ratio.
- R7: The program word is sampled only at reload. A change made mid-cycle leaves the current cycle's length unchanged and sets the length of the following cycle.
- R8: `divOut` rises on the `fin` edge that ends a cycle and stays high for exactly one prescaler period. Measured in VCO cycles, that period is P+1 if A > 0 and P otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin | input | 1 | Prescaler output clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; reloads the counters |
| progWord | input | 16 | Binary program value NT (N in upper bits, A in low a bits) |
| pSel | input | 2 | Prescaler modulus select: 0→8, 1→16, 2→32, 3→64 |
| modCtl | output | 1 | Modulus control to prescaler: 1 selects P+1, 0 selects P |
| divOut | output | 1 | One-period pulse per completed divide cycle |

## Verification
The bench closes the loop with a behavioural prescaler. It counts VCO edges, prescaler periods and swallowed periods between `divOut` edges. It runs every P setting with mixed N/A splits: A small against N, A larger than P/2, and A equal to N. A wrong bit split or a swapped `pSel` decode therefore changes NT by more than one, while an off-by-one in either counter shows up only in the period or swallow counts. A zero-A word isolates the idle swallow path. A word with junk above the N field tests the ignored bits. A program change made mid-cycle tells reload-time sampling apart from continuous sampling.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

  // Strobes from control to datapath, one set per fin edge.
  typedef struct packed {
    logic reload;   // load both counters from the decoded program word
    logic advance;  // step the counters down by one prescaler period
  } swallow_strobe_t;

endpackage

// File: rtl/swallow_word_split.sv
// Splits the binary NT word into the N and A load values according to the
// selected prescaler modulus. One variant per allowed P is built and muxed.
module swallow_word_split #(
  parameter int N_W     = 10,
  parameter int MIN_LOG = 3,
  parameter int NUM_P   = 4,
  parameter int A_W     = 7,
  parameter int WORD_W  = 16,
  parameter int PSEL_W  = 2
) (
  input  logic [WORD_W-1:0] progWord,
  input  logic [PSEL_W-1:0] pSel,
  output logic [N_W-1:0]    nLoad,
  output logic [A_W-1:0]    aLoad
);

  logic [N_W-1:0] nOpt [NUM_P];
  logic [A_W-1:0] aOpt [NUM_P];

  for (genvar g = 0; g < NUM_P; g++) begin : g_mode
    localparam int LOGP = MIN_LOG + g;
    // N takes the bits directly above the swallow field.
    assign nOpt[g] = progWord[LOGP +: N_W];
    // A keeps only its low LOGP bits; everything above is forced to zero.
    assign aOpt[g] = {{(A_W-LOGP){1'b0}}, progWord[LOGP-1:0]};
  end

  assign nLoad = nOpt[pSel];
  assign aLoad = aOpt[pSel];

endmodule

// File: rtl/swallow_ctrl.sv
// Cycle control: decides on each fin edge whether the counters reload or
// step, and registers the divided output pulse.
module swallow_ctrl
  import swallow_pkg::*;
(
  input  logic            fin,
  input  logic            rst,
  input  logic            nLast,
  output swallow_strobe_t stb,
  output logic            divOut
);

  always_comb begin
    stb.reload  = rst | nLast;
    stb.advance = ~(rst | nLast);
  end

  always_ff @(posedge fin) begin
    if (rst) divOut <= 1'b0;
    else     divOut <= nLast;
  end

  // R8: a pulse only follows the edge on which the main counter terminated
  p_pulse_follows_term_r8: assert property (@(posedge fin) disable iff (rst)
    divOut |-> $past(nLast));

  // R8: the terminal edge always produces a pulse on the next period
  p_term_makes_pulse_r8: assert property (@(posedge fin) disable iff (rst)
    nLast |=> divOut);

endmodule

// File: rtl/swallow_dp.sv
// Datapath: main (N) and swallow (A) down-counters clocked by fin.
module swallow_dp
  import swallow_pkg::*;
#(
  parameter int N_W = 10,
  parameter int A_W = 7
) (
  input  logic            fin,
  input  logic            rst,
  input  swallow_strobe_t stb,
  input  logic [N_W-1:0]  nLoad,
  input  logic [A_W-1:0]  aLoad,
  output logic            nLast,
  output logic            modCtl
);

  logic [N_W-1:0] nCnt;
  logic [A_W-1:0] aCnt;

  always_ff @(posedge fin) begin
    if (stb.reload) begin
      nCnt <= nLoad;
      aCnt <= aLoad;
    end else if (stb.advance) begin
      nCnt <= nCnt - 1'b1;
      if (aCnt != '0) aCnt <= aCnt - 1'b1;
    end
  end

  // The last period of a cycle is the one with one count left.
  assign nLast  = (nCnt <= N_W'(1));
  // P+1 is requested while swallow periods remain.
  assign modCtl = (aCnt != '0);

  // R4: the main counter steps by exactly one per prescaler period
  p_n_step_r4: assert property (@(posedge fin) disable iff (rst)
    !stb.reload |=> nCnt == $past(nCnt) - 1'b1);

  // R4: the swallow counter steps while non-zero
  p_a_step_r4: assert property (@(posedge fin) disable iff (rst)
    (!stb.reload && aCnt != '0) |=> aCnt == $past(aCnt) - 1'b1);

  // R5: an exhausted swallow counter stays at zero until reload
  p_a_hold_r5: assert property (@(posedge fin) disable iff (rst)
    (!stb.reload && aCnt == '0) |=> aCnt == '0);

  // R7: reload captures the decoded program word
  p_load_r7: assert property (@(posedge fin) disable iff (rst)
    stb.reload |=> (nCnt == $past(nLoad) && aCnt == $past(aLoad)));

  // R2: the swallow counter top bit is never set
  p_a_upper_zero_r2: assert property (@(posedge fin) disable iff (rst)
    aCnt[A_W-1] == 1'b0);

endmodule

// File: rtl/swallow_div.sv
// Thin top: program word split, cycle control and counter datapath.
module swallow_div
  import swallow_pkg::*;
#(
  parameter int  N_W     = 10,
  parameter int  MIN_LOG = 3,
  parameter int  NUM_P   = 4,
  localparam int MAX_LOG = MIN_LOG + NUM_P - 1,
  localparam int A_W     = MAX_LOG + 1,
  localparam int WORD_W  = N_W + MAX_LOG,
  localparam int PSEL_W  = (NUM_P > 1) ? $clog2(NUM_P) : 1
) (
  input  logic              fin,
  input  logic              rst,
  input  logic [WORD_W-1:0] progWord,
  input  logic [PSEL_W-1:0] pSel,
  output logic              modCtl,
  output logic              divOut
);

  logic [N_W-1:0]  nLoad;
  logic [A_W-1:0]  aLoad;
  logic            nLast;
  swallow_strobe_t stb;

  swallow_word_split #(
    .N_W(N_W), .MIN_LOG(MIN_LOG), .NUM_P(NUM_P),
    .A_W(A_W), .WORD_W(WORD_W), .PSEL_W(PSEL_W)
  ) u_split (
    .progWord(progWord),
    .pSel    (pSel),
    .nLoad   (nLoad),
    .aLoad   (aLoad)
  );

  swallow_ctrl u_ctrl (
    .fin   (fin),
    .rst   (rst),
    .nLast (nLast),
    .stb   (stb),
    .divOut(divOut)
  );

  swallow_dp #(.N_W(N_W), .A_W(A_W)) u_dp (
    .fin   (fin),
    .rst   (rst),
    .stb   (stb),
    .nLoad (nLoad),
    .aLoad (aLoad),
    .nLast (nLast),
    .modCtl(modCtl)
  );

endmodule

// File: tb/swallow_div_bench.sv
module swallow_div_bench;

  logic        vcoClk = 1'b0;
  logic        fin = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] progWord = 16'd100;
  logic [1:0]  pSel = 2'd0;
  logic        modCtl;
  logic        divOut;

  int testsRun = 0;
  int testsFail = 0;

  always #4 vcoClk = ~vcoClk;  // 125 MHz VCO model clock

  swallow_div u_swallow_div (
    .fin(fin), .rst(rst), .progWord(progWord), .pSel(pSel),
    .modCtl(modCtl), .divOut(divOut)
  );

  // Behavioural P/P+1 prescaler: modulus latched one VCO edge after fin rises.
  int presc = 0;
  int curDiv = 8;
  int vcoCount = 0;
  int periodsTot = 0;
  int swallowTot = 0;

  always @(posedge vcoClk) begin
    vcoCount <= vcoCount + 1;
    if (presc == 0) begin
      curDiv     <= modCtl ? (8 << pSel) + 1 : (8 << pSel);
      periodsTot <= periodsTot + 1;
      if (modCtl) swallowTot <= swallowTot + 1;
    end
    if (presc != 0 && presc == curDiv - 1) begin
      presc <= 0;
      fin   <= 1'b1;
    end else begin
      presc <= presc + 1;
      if (presc + 1 == 4) fin <= 1'b0;
    end
  end

  // Measurement, sampled on the falling VCO edge.
  int  markVco = 0, markPer = 0, markSw = 0, riseVco = 0;
  int  lastInterval = 0, lastPer = 0, lastSw = 0, lastHigh = 0;
  int  pulseCnt = 0;
  logic divPrev = 1'b0;

  always @(negedge vcoClk) begin
    if (divOut && !divPrev) begin
      lastInterval = vcoCount - markVco;
      lastPer      = periodsTot - markPer;
      lastSw       = swallowTot - markSw;
      markVco = vcoCount;
      markPer = periodsTot;
      markSw  = swallowTot;
      riseVco = vcoCount;
      pulseCnt++;
    end
    if (!divOut && divPrev) lastHigh = vcoCount - riseVco;
    divPrev = divOut;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitPulse();
    int start = pulseCnt;
    while (pulseCnt == start) @(posedge vcoClk);
  endtask

  // Reset with a new configuration and check the reset state (R1).
  task automatic applyCfg(input logic [1:0] ps, input logic [15:0] w);
    int a = 3 + ps;
    int expA = w & ((1 << a) - 1);
    @(negedge vcoClk);
    rst = 1'b1;
    pSel = ps;
    progWord = w;
    repeat (3) @(posedge fin);
    @(negedge vcoClk);
    check(divOut == 1'b0, "R1", "divOut in reset", divOut, 0);
    check(modCtl == (expA != 0), "R1", "modCtl in reset", modCtl, expA != 0);
    rst = 1'b0;
    waitPulse();
  endtask

  // Measure two cycles and check ratio, period split and pulse width.
  task automatic checkRatio(input logic [1:0] ps, input logic [15:0] w,
                            input string tag);
    int p = 8 << ps;
    int a = 3 + ps;
    int nt = w & ((1 << (10 + a)) - 1);
    int expN = nt >> a;
    int expA = nt & ((1 << a) - 1);
    applyCfg(ps, w);
    for (int k = 0; k < 2; k++) begin
      waitPulse();
      check(lastInterval == nt, tag, "R3 VCO cycles per output", lastInterval, nt);
      check(lastPer == expN, "R4", "prescaler periods per cycle", lastPer, expN);
      check(lastSw == expA, expA == 0 ? "R5" : "R4", "swallowed periods", lastSw, expA);
      if (k == 1)
        check(lastHigh == (expA > 0 ? p + 1 : p), "R8", "divOut high length",
              lastHigh, expA > 0 ? p + 1 : p);
    end
  endtask

  task automatic checkMidWrite();
    int nt1 = 300;
    int nt2 = 517;
    applyCfg(2'd1, 16'(nt1));
    waitPulse();
    repeat (3) @(posedge fin);
    @(negedge vcoClk);
    progWord = 16'(nt2);
    waitPulse();
    check(lastInterval == nt1, "R7", "cycle during write keeps old ratio", lastInterval, nt1);
    waitPulse();
    check(lastInterval == nt2, "R7", "next cycle uses new ratio", lastInterval, nt2);
  endtask

  initial begin
    repeat (190000) @(posedge vcoClk);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    checkRatio(2'd0, 16'd100,  "R2 P=8");     // N=12 A=4
    checkRatio(2'd1, 16'd291,  "R2 P=16");    // N=18 A=3
    checkRatio(2'd2, 16'd1000, "R2 P=32");    // N=31 A=8
    checkRatio(2'd3, 16'd2000, "R2 P=64");    // N=31 A=16
    checkRatio(2'd0, 16'd63,   "R4 N=A");     // N=7 A=7
    checkRatio(2'd1, 16'd160,  "R5 A=0");     // N=10 A=0
    checkRatio(2'd0, 16'hA064, "R6 upper bits"); // bits 13,15 set, NT=100
    checkMidWrite();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule